// File: doc/BRIEF.md
# Accumulator CPU Core

A multi-cycle processor core for a small 24-bit accumulator machine. It reads three-byte instructions from a 32,768-byte, byte-wide memory. It runs them through a fetch, decode, operand-load, execute and store sequence. All arithmetic pairs the accumulator with a word from memory. A compare leaves a three-way condition code, and separate jumps test that code. Subroutine calls keep the return address in a link register rather than on a stack.

Byte input and output pass through the low 8 bits of the accumulator. The number of the device being addressed is the memory byte that the instruction points at. A readiness test lets a program spin in a jump loop until the device is ready. The memory interface is a single synchronous port: the address is presented in one cycle and the read byte returns in the next. Words are assembled one byte at a time.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and directly after its release, `halted`, `div_err`, `mem_we`, `dev_rd` and `dev_wr` are 0, and the first instruction is fetched from address 0.
- R2: An instruction occupies three bytes at PC, PC+1 and PC+2: the opcode byte, then {index flag, address bits 14..8}, then address bits 7..0. With the index flag set, the effective address is the 15-bit address plus the low 15 bits of X. Opcodes: LDA 00h, LDX 04h, LDL 08h, STA 0Ch, STX 10h, STL 14h, ADD 18h, SUB 1Ch, MUL 20h, DIV 24h, COMP 28h, TIX 2Ch, JEQ 30h, JGT 34h, JLT 38h, J 3Ch, JSUB 48h, RSUB 4Ch, LDCH 50h, STCH 54h, RD D8h, WD DCh, TD E0h.
- R3: A word is three consecutive bytes with the most significant byte at the lowest address. LDA, LDX and LDL load one. STA, STX and STL write one in consecutive-address cycles.
- R4: ADD, SUB and MUL combine A with a memory word and keep the low 24 bits of the result in A, wrapping modulo 2^24.
- R5: DIV replaces A with the signed quotient truncated toward zero. A zero divisor leaves A unchanged and sets `div_err`, which then stays set until reset.
- R6: COMP sets the condition code to less, equal or greater by a signed comparison of A with the memory word. JLT, JEQ and JGT jump to the effective address only when the code matches. Reset leaves the code at equal.
- R7: JSUB stores the address of the following instruction in L and jumps. RSUB jumps to the address held in L.
- R8: LDCH replaces only A[7:0] with the addressed byte. STCH writes A[7:0] to the addressed byte only.
- R9: TIX increments X by one, then compares the new X with the memory word (signed) and sets the condition code.
- R10: TD, RD and WD take the device number from the memory byte at the effective address. TD sets the code to less when `dev_ready` is 1 and to equal when it is 0. RD loads `dev_rdata` into A[7:0]. WD presents A[7:0] on `dev_wdata`. Each `dev_rd` or `dev_wr` strobe lasts one cycle.
- R11: An opcode outside the list in R2 raises `halted`. It then stays high until reset, with no memory write and no device strobe.
- R12: J always loads PC with the effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 15 | Byte address of the memory port |
| mem_we | output | 1 | Write enable for the memory port |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid one cycle after its address |
| dev_num | output | 8 | Device number of the current I/O instruction |
| dev_ready | input | 1 | Device ready flag tested by TD |
| dev_rdata | input | 8 | Byte supplied by the device on a read |
| dev_rd | output | 1 | One-cycle read strobe |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_wr | output | 1 | One-cycle write strobe |
| halted | output | 1 | Core stopped on an unknown opcode |
| div_err | output | 1 | Sticky division-by-zero flag |

## Verification
TIX updates X and sets the condition code in the same execute cycle, and the compare must see the incremented X. A copy loop bounded by TIX gets this wrong by one if the compare uses the old value. The test judges it by the exact number of bytes copied, an untouched byte just past the end, and the final X. A divide by zero raises the error flag in the same cycle that A would have been written. The test follows it with a store and checks that A kept the value of the previous valid quotient.

// File: rtl/acc_core.sv
module acc_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [14:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  dev_num,
  input  logic        dev_ready,
  input  logic [7:0]  dev_rdata,
  output logic        dev_rd,
  output logic [7:0]  dev_wdata,
  output logic        dev_wr,
  output logic        halted,
  output logic        div_err
);
  localparam logic [7:0] OP_LDA = 8'h00, OP_LDX = 8'h04, OP_LDL = 8'h08, OP_STA = 8'h0C,
    OP_STX = 8'h10, OP_STL = 8'h14, OP_ADD = 8'h18, OP_SUB = 8'h1C, OP_MUL = 8'h20,
    OP_DIV = 8'h24, OP_COMP = 8'h28, OP_TIX = 8'h2C, OP_JEQ = 8'h30, OP_JGT = 8'h34,
    OP_JLT = 8'h38, OP_J = 8'h3C, OP_JSUB = 8'h48, OP_RSUB = 8'h4C, OP_LDCH = 8'h50,
    OP_STCH = 8'h54, OP_RD = 8'hD8, OP_WD = 8'hDC, OP_TD = 8'hE0;
  localparam logic [23:0] SW_EQ = 24'd0, SW_LT = 24'd1, SW_GT = 24'd2;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_LOAD, S_EXEC, S_STORE, S_HALT} state_t;

  state_t      state;
  logic [1:0]  cnt;
  logic [23:0] a, x, l, pc, sw, ir, opnd;

  wire [7:0]  op      = ir[23:16];
  wire [14:0] ea      = ir[14:0] + (ir[15] ? x[14:0] : 15'd0);
  wire [23:0] ea_w    = {9'd0, ea};
  wire        byte_op = (op == OP_LDCH) || (op == OP_TD) || (op == OP_RD) || (op == OP_WD);
  wire [1:0]  last_ld = byte_op ? 2'd1 : 2'd3;
  wire [1:0]  last_st = (op == OP_STCH) ? 2'd0 : 2'd2;
  wire [23:0] x_inc   = x + 24'd1;
  wire [23:0] prod    = a * opnd;
  wire [23:0] quo     = (opnd == 24'd0) ? a : $unsigned($signed(a) / $signed(opnd));

  logic [23:0] st_src;
  always_comb begin
    case (op)
      OP_STX:  st_src = x;
      OP_STL:  st_src = l;
      default: st_src = a;
    endcase
  end

  function automatic logic [23:0] cmp_sw(input logic [23:0] p, input logic [23:0] q);
    if ($signed(p) < $signed(q)) return SW_LT;
    if (p == q) return SW_EQ;
    return SW_GT;
  endfunction

  assign mem_addr  = (state == S_FETCH) ? pc[14:0] + {13'd0, cnt} : ea + {13'd0, cnt};
  assign mem_we    = (state == S_STORE);
  assign mem_wdata = (op == OP_STCH) ? a[7:0] :
                     (cnt == 2'd0) ? st_src[23:16] : (cnt == 2'd1) ? st_src[15:8] : st_src[7:0];
  assign dev_num   = opnd[7:0];
  assign dev_wdata = a[7:0];
  assign dev_rd    = (state == S_EXEC) && (op == OP_RD);
  assign dev_wr    = (state == S_EXEC) && (op == OP_WD);
  assign halted    = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH; cnt <= 2'd0; a <= '0; x <= '0; l <= '0; pc <= '0;
      sw <= SW_EQ; ir <= '0; opnd <= '0; div_err <= 1'b0;
    end else begin
      case (state)
        S_FETCH: begin
          if (cnt != 2'd0) ir <= {ir[15:0], mem_rdata};
          if (cnt == 2'd3) begin
            cnt <= 2'd0; pc <= pc + 24'd3; state <= S_DEC;
          end else cnt <= cnt + 2'd1;
        end
        S_DEC: begin
          state <= S_FETCH;
          case (op)
            OP_J:    pc <= ea_w;
            OP_JEQ:  if (sw == SW_EQ) pc <= ea_w;
            OP_JLT:  if (sw == SW_LT) pc <= ea_w;
            OP_JGT:  if (sw == SW_GT) pc <= ea_w;
            OP_JSUB: begin l <= pc; pc <= ea_w; end
            OP_RSUB: pc <= l;
            OP_STA, OP_STX, OP_STL, OP_STCH: state <= S_STORE;
            OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_COMP, OP_TIX,
            OP_LDCH, OP_TD, OP_RD, OP_WD: state <= S_LOAD;
            default: state <= S_HALT;
          endcase
        end
        S_LOAD: begin
          if (cnt != 2'd0) opnd <= {opnd[15:0], mem_rdata};
          if (cnt == last_ld) begin
            cnt <= 2'd0; state <= S_EXEC;
          end else cnt <= cnt + 2'd1;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_LDA:  a <= opnd;
            OP_LDX:  x <= opnd;
            OP_LDL:  l <= opnd;
            OP_ADD:  a <= a + opnd;
            OP_SUB:  a <= a - opnd;
            OP_MUL:  a <= prod;
            OP_DIV:  begin a <= quo; if (opnd == 24'd0) div_err <= 1'b1; end
            OP_COMP: sw <= cmp_sw(a, opnd);
            OP_TIX:  begin x <= x_inc; sw <= cmp_sw(x_inc, opnd); end
            OP_LDCH: a[7:0] <= opnd[7:0];
            OP_RD:   a[7:0] <= dev_rdata;
            OP_TD:   sw <= dev_ready ? SW_LT : SW_EQ;
            default: ;
          endcase
        end
        S_STORE: begin
          if (cnt == last_st) begin
            cnt <= 2'd0; state <= S_FETCH;
          end else cnt <= cnt + 2'd1;
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [14:0] mem_addr,
  input logic        mem_we,
  input logic        dev_rd,
  input logic        dev_wr,
  input logic        halted,
  input logic        div_err
);
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_addr == 15'd0 && !mem_we && !halted && !div_err));

  p_word_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 15'd1));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);

  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> !dev_rd);

  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |=> !dev_wr);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !dev_rd && !dev_wr));
endmodule

bind acc_core acc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .dev_rd(dev_rd), .dev_wr(dev_wr), .halted(halted), .div_err(div_err)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  localparam logic [7:0] LDA = 8'h00, LDX = 8'h04, LDL = 8'h08, STA = 8'h0C, STX = 8'h10,
    STL = 8'h14, ADD = 8'h18, SUB = 8'h1C, MUL = 8'h20, DIV = 8'h24, COMP = 8'h28,
    TIX = 8'h2C, JEQ = 8'h30, JGT = 8'h34, JLT = 8'h38, JMP = 8'h3C, JSUB = 8'h48,
    RSUB = 8'h4C, LDCH = 8'h50, STCH = 8'h54, RD = 8'hD8, WD = 8'hDC, TD = 8'hE0, BAD = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic mem_we, dev_rd, dev_wr, halted, div_err;
  logic [7:0] mem_wdata, mem_rdata, dev_num, dev_wdata, dev_rdata;
  logic dev_ready = 1'b0;
  logic dev_clr = 1'b0;
  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] wr_num, wr_dat;
  logic [7:0] mem [0:4095];

  always #5 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_num(dev_num), .dev_ready(dev_ready), .dev_rdata(dev_rdata),
    .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_wr(dev_wr), .halted(halted), .div_err(div_err)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  assign dev_rdata = dev_num ^ 8'h5A;

  always @(posedge clk) begin
    if (dev_clr) begin
      rd_cnt <= 0; wr_cnt <= 0;
    end else begin
      if (dev_rd) rd_cnt <= rd_cnt + 1;
      if (dev_wr) begin wr_cnt <= wr_cnt + 1; wr_num <= dev_num; wr_dat <= dev_wdata; end
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill();
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
  endtask

  task automatic ins(input int ad, input logic [7:0] op, input logic xb, input logic [14:0] ta);
    mem[ad] = op; mem[ad+1] = {xb, ta[14:8]}; mem[ad+2] = ta[7:0];
  endtask

  task automatic wrd(input int ad, input logic [23:0] v);
    mem[ad] = v[23:16]; mem[ad+1] = v[15:8]; mem[ad+2] = v[7:0];
  endtask

  function automatic logic [23:0] rdw(input int ad);
    return {mem[ad], mem[ad+1], mem[ad+2]};
  endfunction

  task automatic run(input int max_cyc, input string tag);
    @(negedge clk); rst_n = 1'b0; dev_clr = 1'b1;
    repeat (2) @(negedge clk);
    dev_clr = 1'b0; rst_n = 1'b1;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    chk({tag, " program reached halt R11"}, {23'd0, halted}, 24'd1);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 halted in reset", {23'd0, halted}, 24'd0);
    chk("R1 div_err in reset", {23'd0, div_err}, 24'd0);
    chk("R1 strobes and we in reset", {21'd0, mem_we, dev_rd, dev_wr}, 24'd0);
    chk("R1 fetch address", {9'd0, mem_addr}, 24'd0);
  endtask

  task automatic t_arith();
    fill();
    ins(0, LDA, 0, 15'h400); ins(3, ADD, 0, 15'h403); ins(6, STA, 0, 15'h500);
    ins(9, LDA, 0, 15'h406); ins(12, SUB, 0, 15'h409); ins(15, STA, 0, 15'h503);
    ins(18, LDA, 0, 15'h40C); ins(21, MUL, 0, 15'h40F); ins(24, STA, 0, 15'h506);
    ins(27, LDA, 0, 15'h412); ins(30, MUL, 0, 15'h412); ins(33, STA, 0, 15'h509);
    ins(36, LDX, 0, 15'h415); ins(39, LDA, 1, 15'h400); ins(42, STA, 0, 15'h50C);
    mem[45] = BAD;
    wrd(15'h400, 24'h7FFFFF); wrd(15'h403, 24'h000001);
    wrd(15'h406, 24'h000005); wrd(15'h409, 24'h000007);
    wrd(15'h40C, 24'hFFFFFD); wrd(15'h40F, 24'h000005);
    wrd(15'h412, 24'h001000); wrd(15'h415, 24'h000006);
    run(400, "arith");
    chk("R4 ADD wraps to negative", rdw(15'h500), 24'h800000);
    chk("R4 SUB below zero", rdw(15'h503), 24'hFFFFFE);
    chk("R4 MUL signed low bits", rdw(15'h506), 24'hFFFFF1);
    chk("R4 MUL truncates to 24 bits", rdw(15'h509), 24'h000000);
    chk("R2 indexed load uses X", rdw(15'h50C), 24'h000005);
    chk("R3 STA byte order", {16'd0, mem[15'h500]}, 24'h000080);
    chk("R5 no div_err without DIV", {23'd0, div_err}, 24'd0);
  endtask

  task automatic t_div();
    fill();
    ins(0, LDA, 0, 15'h400); ins(3, DIV, 0, 15'h403); ins(6, STA, 0, 15'h500);
    ins(9, DIV, 0, 15'h406); ins(12, STA, 0, 15'h503); mem[15] = BAD;
    wrd(15'h400, 24'hFFFF9C); wrd(15'h403, 24'd7); wrd(15'h406, 24'd0);
    run(300, "div");
    chk("R5 signed quotient toward zero", rdw(15'h500), 24'hFFFFF2);
    chk("R5 zero divisor keeps A", rdw(15'h503), 24'hFFFFF2);
    chk("R5 div_err set", {23'd0, div_err}, 24'd1);
    repeat (5) @(negedge clk);
    chk("R5 div_err sticky", {23'd0, div_err}, 24'd1);
  endtask

  task automatic cmp_case(input logic [23:0] va, input logic [23:0] vb, input logic [23:0] exp,
                          input string tag);
    fill();
    ins(0, LDA, 0, 15'h400); ins(3, COMP, 0, 15'h403);
    ins(6, JLT, 0, 15'd18); ins(9, JEQ, 0, 15'd24); ins(12, JGT, 0, 15'd30);
    mem[15] = BAD;
    ins(18, LDA, 0, 15'h406); ins(21, JMP, 0, 15'd36);
    ins(24, LDA, 0, 15'h409); ins(27, JMP, 0, 15'd36);
    ins(30, LDA, 0, 15'h40C); ins(33, JMP, 0, 15'd36);
    ins(36, STA, 0, 15'h500); mem[39] = BAD;
    wrd(15'h400, va); wrd(15'h403, vb);
    wrd(15'h406, 24'd1); wrd(15'h409, 24'd2); wrd(15'h40C, 24'd3);
    run(300, "cmp");
    chk(tag, rdw(15'h500), exp);
  endtask

  task automatic t_cmp();
    cmp_case(24'd5, 24'd9, 24'd1, "R6 less takes JLT, R12 J");
    cmp_case(24'd9, 24'd9, 24'd2, "R6 equal takes JEQ");
    cmp_case(24'd9, 24'd5, 24'd3, "R6 greater takes JGT");
    cmp_case(24'hFFFFFF, 24'd1, 24'd1, "R6 signed compare");
  endtask

  task automatic t_sub();
    fill();
    ins(0, JSUB, 0, 15'd30); ins(3, STA, 0, 15'h500); ins(6, STL, 0, 15'h503);
    mem[9] = BAD;
    ins(30, LDA, 0, 15'h400); ins(33, RSUB, 0, 15'd0);
    ins(12, LDL, 0, 15'h406); ins(15, RSUB, 0, 15'd0);
    wrd(15'h400, 24'hABCDEF); wrd(15'h406, 24'd9);
    run(300, "sub");
    chk("R7 subroutine body ran", rdw(15'h500), 24'hABCDEF);
    chk("R7 L holds return address", rdw(15'h503), 24'd3);
  endtask

  task automatic t_byte();
    fill();
    ins(0, LDA, 0, 15'h400); ins(3, LDX, 0, 15'h403); ins(6, LDCH, 1, 15'h410);
    ins(9, STA, 0, 15'h500); ins(12, STCH, 1, 15'h600); mem[15] = BAD;
    wrd(15'h400, 24'h123456); wrd(15'h403, 24'd2);
    mem[15'h412] = 8'hAB;
    run(300, "byte");
    chk("R8 LDCH keeps A upper bits", rdw(15'h500), 24'h1234AB);
    chk("R8 STCH writes addressed byte", {16'd0, mem[15'h602]}, 24'h0000AB);
    chk("R8 STCH neighbours untouched", {8'd0, mem[15'h601], mem[15'h603]}, 24'h00EEEE);
  endtask

  task automatic t_tix();
    fill();
    ins(0, LDX, 0, 15'h400);
    ins(3, LDCH, 1, 15'h410); ins(6, STCH, 1, 15'h600); ins(9, TIX, 0, 15'h403);
    ins(12, JLT, 0, 15'd3); ins(15, STX, 0, 15'h500); mem[18] = BAD;
    wrd(15'h400, 24'd0); wrd(15'h403, 24'd5);
    for (int i = 0; i < 6; i++) mem[15'h410 + i] = 8'h30 + 8'(i);
    run(1000, "tix");
    for (int i = 0; i < 5; i++)
      chk("R9 copied byte", {16'd0, mem[15'h600 + i]}, {16'd0, 8'h30 + 8'(i)});
    chk("R9 stops at limit", {16'd0, mem[15'h605]}, 24'h0000EE);
    chk("R9 final X", rdw(15'h500), 24'd5);
  endtask

  task automatic t_io();
    fill();
    ins(0, TD, 0, 15'h400); ins(3, JEQ, 0, 15'd0); ins(6, RD, 0, 15'h400);
    ins(9, STCH, 0, 15'h500); ins(12, LDCH, 0, 15'h401); ins(15, WD, 0, 15'h400);
    mem[18] = BAD;
    mem[15'h400] = 8'h21; mem[15'h401] = 8'h3C;
    dev_ready = 1'b0;
    fork
      begin repeat (80) @(negedge clk); dev_ready = 1'b1; end
    join_none
    run(1000, "io");
    chk("R10 RD byte from device", {16'd0, mem[15'h500]}, 24'h00007B);
    chk("R10 one read strobe", 24'(rd_cnt), 24'd1);
    chk("R10 one write strobe", 24'(wr_cnt), 24'd1);
    chk("R10 write device number", {16'd0, wr_num}, 24'h000021);
    chk("R10 write data", {16'd0, wr_dat}, 24'h00003C);
    dev_ready = 1'b0;
  endtask

  task automatic t_halt();
    fill();
    mem[0] = BAD; ins(3, STA, 0, 15'h500);
    run(50, "halt");
    repeat (20) @(negedge clk);
    chk("R11 halt sticky", {23'd0, halted}, 24'd1);
    chk("R11 no store after halt", {16'd0, mem[15'h500]}, 24'h0000EE);
    chk("R11 no write enable", {23'd0, mem_we}, 24'd0);
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_arith();
    t_div();
    t_cmp();
    t_sub();
    t_byte();
    t_tix();
    t_io();
    t_halt();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule